// File: doc/BRIEF.md
# Card Memory Cycle Length Controller

This block decides how long each memory cycle sent to a card lasts and times it. The host side raises a one-clock start request, together with the timing controls of the window that was hit: a width bit, a zero-wait bit and a two-bit wait-state count. The block holds a command-active strobe high for the computed number of clocks, then gives a one-clock completion pulse. Address translation, data steering and the host bus handshake belong to neighbouring logic.

The timing controls are captured only when a start is accepted, so the window registers may change while a cycle is under way. A busy flag covers the whole cycle, from the clock after the accepted start through the completion pulse. Start requests that arrive while busy is high are dropped.

Top module: `card_cycle_timer`

## Requirements
- R1: While reset is asserted and in the first clock after its release, cmdActive, donePulse and busy are all low.
- R2: The width bit selects the cycle type: wideData = 0 means an 8-bit cycle and wideData = 1 means a 16-bit cycle. With zeroWait = 0, an 8-bit cycle holds cmdActive high for exactly 6 clocks.
- R3: With zeroWait = 0, a 16-bit cycle holds cmdActive high for 3 + waitStates clocks, where waitStates is read as an unsigned value 0 to 3.
- R4: With zeroWait = 1, an 8-bit cycle holds cmdActive high for exactly 3 clocks.
- R5: With zeroWait = 1, a 16-bit cycle holds cmdActive high for exactly 2 clocks, whatever waitStates holds.
- R6: waitStates has no effect on the length of an 8-bit cycle.
- R7: donePulse is high for exactly one clock, in the clock right after cmdActive falls, and never while cmdActive is high.
- R8: busy rises in the clock after an accepted start, together with cmdActive, and stays high through the donePulse clock. It is low in the clock after that.
- R9: A startPulse seen while busy is high, including in the donePulse clock, is ignored. A start in the first clock with busy low is accepted.
- R10: wideData, zeroWait and waitStates are sampled only in the clock of an accepted start. Changing them during a cycle does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period stands for one ISA-equivalent clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-clock request to begin a card memory cycle |
| wideData | input | 1 | Width of the hit window: 0 = 8-bit, 1 = 16-bit |
| zeroWait | input | 1 | Zero-wait-state control of the hit window |
| waitStates | input | WS_W (2) | Extra clocks added to 16-bit cycles without zero-wait |
| cmdActive | output | 1 | High for the duration of the card command |
| donePulse | output | 1 | One-clock completion pulse after cmdActive falls |
| busy | output | 1 | High from the accepted start through donePulse |

## Verification
An accepted start is sampled on rising edge k. cmdActive and busy are high from the clock after edge k. cmdActive stays high through the clock after edge k+L-1, where L is the cycle length. donePulse is high in the clock after edge k+L, and busy is low again after edge k+L+1. The bench sweeps every combination of width, zero-wait and wait-state values. It counts cmdActive clocks at each falling clock edge, one per register stage, and checks donePulse and busy at the exact clock the timing above predicts. Every combination is run a second time while the bench sends start requests and scrambles the controls on every busy clock. The second run must produce the same length, and busy must drop on time, which shows at the ports that those starts were dropped.

// File: rtl/card_cyc_pkg.sv
package card_cyc_pkg;

  // Strobes sent from the sequencer to the length datapath
  typedef struct packed {
    logic load;   // capture the length of a newly accepted cycle
    logic dec;    // count one command clock off
  } cycStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cycState_t;

endpackage

// File: rtl/card_cyc_dp.sv
module card_cyc_dp
  import card_cyc_pkg::*;
#(
  parameter int WS_W      = 2,
  parameter int STD8_LEN  = 6,
  parameter int STD16_LEN = 3,
  parameter int ZW8_LEN   = 3,
  parameter int ZW16_LEN  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  cycStrobe_t      strobe,
  input  logic            wideData,
  input  logic            zeroWait,
  input  logic [WS_W-1:0] waitStates,
  output logic            lastBeat
);

  localparam int WS_MAX   = (1 << WS_W) - 1;
  localparam int WIDE_MAX = STD16_LEN + WS_MAX;
  localparam int MAX_A    = (STD8_LEN > ZW8_LEN) ? STD8_LEN : ZW8_LEN;
  localparam int MAX_B    = (WIDE_MAX > ZW16_LEN) ? WIDE_MAX : ZW16_LEN;
  localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] lenCalc;
  logic [CNT_W-1:0] remCnt;

  // Zero-wait takes precedence; the wait-state count only stretches wide cycles
  always_comb begin
    if (!wideData) begin
      lenCalc = zeroWait ? CNT_W'(ZW8_LEN) : CNT_W'(STD8_LEN);
    end else if (zeroWait) begin
      lenCalc = CNT_W'(ZW16_LEN);
    end else begin
      lenCalc = CNT_W'(STD16_LEN) + CNT_W'(waitStates);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt <= '0;
    end else if (strobe.load) begin
      remCnt <= lenCalc;
    end else if (strobe.dec) begin
      remCnt <= remCnt - CNT_W'(1);
    end
  end

  assign lastBeat = (remCnt == CNT_W'(1));

endmodule

// File: rtl/card_cyc_ctl.sv
module card_cyc_ctl
  import card_cyc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       lastBeat,
  output cycStrobe_t strobe,
  output logic       cmdActive,
  output logic       donePulse,
  output logic       busy
);

  cycState_t state, stateNxt;

  always_comb begin
    stateNxt     = state;
    strobe       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          stateNxt    = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.dec = 1'b1;
        if (lastBeat) stateNxt = ST_DONE;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign cmdActive = (state == ST_RUN);
  assign donePulse = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/card_cycle_timer.sv
module card_cycle_timer
  import card_cyc_pkg::*;
#(
  parameter int WS_W      = 2,
  parameter int STD8_LEN  = 6,
  parameter int STD16_LEN = 3,
  parameter int ZW8_LEN   = 3,
  parameter int ZW16_LEN  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            wideData,
  input  logic            zeroWait,
  input  logic [WS_W-1:0] waitStates,
  output logic            cmdActive,
  output logic            donePulse,
  output logic            busy
);

  cycStrobe_t strobe;
  logic       lastBeat;

  card_cyc_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .lastBeat  (lastBeat),
    .strobe    (strobe),
    .cmdActive (cmdActive),
    .donePulse (donePulse),
    .busy      (busy)
  );

  card_cyc_dp #(
    .WS_W     (WS_W),
    .STD8_LEN (STD8_LEN),
    .STD16_LEN(STD16_LEN),
    .ZW8_LEN  (ZW8_LEN),
    .ZW16_LEN (ZW16_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wideData  (wideData),
    .zeroWait  (zeroWait),
    .waitStates(waitStates),
    .lastBeat  (lastBeat)
  );

endmodule

// File: rtl/card_cycle_timer_chk.sv
module card_cycle_timer_chk #(
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 6
) (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic cmdActive,
  input logic donePulse,
  input logic busy
);

  logic [7:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runLen <= '0;
    else if (cmdActive) runLen <= runLen + 8'd1;
    else                runLen <= '0;
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7
  done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdActive) |-> donePulse);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!cmdActive && $past(cmdActive)));

  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdActive || donePulse) |-> busy);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> cmdActive);

  // R9
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdActive) |-> ($past(startPulse) && !$past(busy)));

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdActive) |-> (runLen >= 8'(MIN_LEN) && runLen <= 8'(MAX_LEN)));

endmodule

bind card_cycle_timer card_cycle_timer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .cmdActive (cmdActive),
  .donePulse (donePulse),
  .busy      (busy)
);

// File: tb/tb_card_cycle_timer.sv
module tb_card_cycle_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       wideData = 1'b0;
  logic       zeroWait = 1'b0;
  logic [1:0] waitStates = 2'd0;
  logic       cmdActive, donePulse, busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cycle_timer dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .wideData(wideData),
    .zeroWait(zeroWait), .waitStates(waitStates),
    .cmdActive(cmdActive), .donePulse(donePulse), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input bit w, input bit z, input int ws);
    if (!w) return z ? 3 : 6;
    if (z)  return 2;
    return 3 + ws;
  endfunction

  // One full cycle; disturb sends starts and scrambles controls while busy
  task automatic runCycle(input bit w, input bit z, input int ws, input bit disturb);
    int n = 0;
    int exp = expLen(w, z, ws);
    string tag;
    if (!w)     tag = z ? "R4" : (ws != 0 ? "R6" : "R2");
    else        tag = z ? "R5" : "R3";
    @(negedge clk);
    wideData = w; zeroWait = z; waitStates = 2'(ws); startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check("R8 busy with first command clock", int'(busy), 1);
    while (cmdActive && n < 20) begin
      n++;
      if (!busy) check("R8 busy during command", int'(busy), 1);
      if (disturb) begin
        startPulse = 1'b1; wideData = ~wideData; zeroWait = ~zeroWait;
        waitStates = waitStates + 2'd1;
      end
      @(negedge clk);
    end
    check(disturb ? {tag, " R10 length with changing controls"} : {tag, " length"}, n, exp);
    check("R7 done after command", int'(donePulse), 1);
    check("R8 busy in done clock", int'(busy), 1);
    if (disturb) startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check("R7 done lasts one clock", int'(donePulse), 0);
    check(disturb ? "R9 busy falls despite starts" : "R8 busy falls", int'(busy), 0);
    check("R9 no command from ignored start", int'(cmdActive), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    startPulse = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs stay low in reset even with start requested
    check("R1 cmdActive in reset", int'(cmdActive), 0);
    check("R1 donePulse in reset", int'(donePulse), 0);
    check("R1 busy in reset", int'(busy), 0);
    startPulse = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 cmdActive after reset", int'(cmdActive), 0);
    check("R1 busy after reset", int'(busy), 0);

    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 2; w++)
        for (int z = 0; z < 2; z++)
          for (int ws = 0; ws < 4; ws++)
            runCycle(bit'(w), bit'(z), ws, bit'(d));

    // R9: back-to-back, start in the first idle clock is accepted
    runCycle(1'b1, 1'b0, 3, 1'b0);
    runCycle(1'b0, 1'b1, 2, 1'b1);
    summary();
  end

endmodule